// File: doc/BRIEF.md
# Register-Mapped Synchronous Serial Port Controller

This block sits on a simple 32-bit peripheral bus and buffers words for a synchronous serial link. Software writes words into an eight-entry send queue through the data register. A transfer engine drains that queue one word at a time and pushes each result into an eight-entry receive queue, which software empties through reads of the same data register. Each word either goes out through an external exchange port with a request/acknowledge handshake, which returns one word for every word sent, or is turned straight back into the receive queue when loopback is selected.

A word-size field masks data to between 1 and 16 bits, both when a word enters the send queue and when a result is captured. Status flags, raw and masked interrupt registers and one combined interrupt line report queue levels against half-full thresholds. A block of read-only identification bytes sits at the top of the 4 KiB window. Clock generation, framing, slave operation and DMA are not part of this block. The prescale and DMA control registers are only stored or accepted.

The engine is a two-state machine. In `ENG_IDLE` it starts a transfer when the port is enabled, the send queue holds a word and the receive queue has room. In loopback mode it pops and pushes in the same cycle and stays in `ENG_IDLE`. Otherwise it pops, latches the word and takes the transition to `ENG_EXCH`. In `ENG_EXCH` it holds the request and the word until the acknowledge arrives, then pushes the masked reply and returns to `ENG_IDLE`.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset, status reads 0x03, raw interrupt reads 0x08, the interrupt mask reads 0, the interrupt line is low and both queues are empty.
- R2: The low 4 bits of control register 0 (offset 0x00), value n, set a data mask of n+1 ones. Words written to the send queue are ANDed with the mask in force at the write, and captured results are ANDed with the mask in force at the capture.
- R3: With control register 1 (offset 0x04) bit 0 set, each word popped from the send queue enters the receive queue unchanged and in order, and the exchange request stays low.
- R4: With loopback off, the controller raises xfer_req and holds xfer_out stable and equal to the popped word until xfer_ack. It then stores xfer_in under the mask and has at most one exchange in flight.
- R5: While control register 1 bit 1 (enable) is clear, no transfer happens and written words stay in the send queue.
- R6: A data-register (offset 0x08) write while the send queue holds 8 words is dropped.
- R7: The engine never pushes into a full receive queue. It stalls and resumes one word per freed slot, and order is kept.
- R8: A data-register read with an empty receive queue returns 0 and changes no state.
- R9: Status (offset 0x0C) bits are: bit0 send queue empty, bit1 send queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy. Busy is set whenever the send queue is not empty.
- R10: Raw interrupt (0x18) bit2 is set when the receive queue holds at least 4 words and bit3 is set when the send queue holds at most 4. Masked status (0x1C) reads raw AND mask (0x14), and irq is high when that value is non-zero.
- R11: Reads from 0xFE0 to 0xFFC return one identification byte per word: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Control register 0 reads back 16 bits and control register 1 reads back 4 bits. Prescale (0x10) keeps the low 8 bits of a write. DMA control (0x20) and unmapped offsets read 0 and ignore writes, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally in the access cycle |
| irq | output | 1 | Combined interrupt |
| xfer_req | output | 1 | Exchange request |
| xfer_out | output | WORD_W | Word sent during the exchange |
| xfer_ack | input | 1 | Exchange acknowledge |
| xfer_in | input | WORD_W | Word returned with the acknowledge |

## Verification
The bench builds the block with its defaults: eight-entry queues and a 16-bit word. With eight entries, a full send queue, a dropped ninth write, a full receive queue with a stalled engine and both interrupt thresholds can each be reached with a handful of writes. The 16-bit word lets the mask run from a single nibble to full width, and a 12-bit setting shows that a reply from the exchange port is trimmed at capture.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int BUS_AW = 12;

    localparam logic [BUS_AW-1:0] OFS_CTRL0  = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_CTRL1  = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_DATA   = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_STAT   = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_PRESC  = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_IMASK  = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_RAW    = 12'h018;
    localparam logic [BUS_AW-1:0] OFS_MASKED = 12'h01C;
    localparam logic [BUS_AW-1:0] OFS_DMA    = 12'h020;

    typedef enum logic [0:0] {
        ENG_IDLE = 1'b0,
        ENG_EXCH = 1'b1
    } eng_state_t;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h22;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         loopback,
    input  logic [W-1:0] mask,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_head,
    input  logic         rx_full,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_data,
    output logic         xfer_req,
    output logic [W-1:0] xfer_out,
    input  logic         xfer_ack,
    input  logic [W-1:0] xfer_in
);
    eng_state_t state_q, state_d;
    logic [W-1:0] word_q;
    logic         start;

    assign start = enable && !tx_empty && !rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ENG_IDLE && start && !loopback) word_q <= tx_head;
        end
    end

    always_comb begin
        state_d  = state_q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        rx_data  = '0;
        xfer_req = 1'b0;
        xfer_out = word_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (start) begin
                    tx_pop = 1'b1;
                    if (loopback) begin
                        rx_push = 1'b1;
                        rx_data = tx_head & mask;
                    end else begin
                        state_d = ENG_EXCH;
                    end
                end
            end
            ENG_EXCH: begin
                xfer_req = 1'b1;
                if (xfer_ack) begin
                    rx_push = 1'b1;
                    rx_data = xfer_in & mask;
                    state_d = ENG_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SZ_W  = $clog2(WORD_W),
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              xfer_req,
    output logic [WORD_W-1:0] xfer_out,
    input  logic              xfer_ack,
    input  logic [WORD_W-1:0] xfer_in
);
    logic [15:0]       ctrl0_q;
    logic [3:0]        ctrl1_q;
    logic [7:0]        presc_q;
    logic [3:0]        imask_q;
    logic [WORD_W-1:0] word_mask;
    logic [11:0]       ofs;
    logic              wr_en, rd_en;

    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic [WORD_W-1:0] tx_head, rx_head, rx_wdata;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [4:0]        status;
    logic [3:0]        raw_int;

    assign ofs   = {bus_addr[11:2], 2'b00};
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_comb begin
        for (int i = 0; i < WORD_W; i++)
            word_mask[i] = (i <= int'(ctrl0_q[SZ_W-1:0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            presc_q <= '0;
            imask_q <= '0;
        end else if (wr_en) begin
            unique case (ofs)
                OFS_CTRL0: ctrl0_q <= bus_wdata[15:0];
                OFS_CTRL1: ctrl1_q <= bus_wdata[3:0];
                OFS_PRESC: presc_q <= bus_wdata[7:0];
                OFS_IMASK: imask_q <= bus_wdata[3:0];
                default:   ;
            endcase
        end
    end

    assign tx_empty = (tx_cnt == '0);
    assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
    assign rx_empty = (rx_cnt == '0);
    assign rx_full  = (rx_cnt == CNT_W'(DEPTH));
    assign tx_push  = wr_en && (ofs == OFS_DATA) && !tx_full;
    assign rx_pop   = rd_en && (ofs == OFS_DATA) && !rx_empty;

    ssp_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push),
        .wdata(bus_wdata[WORD_W-1:0] & word_mask),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt)
    );

    ssp_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    ssp_engine #(.W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl1_q[1]), .loopback(ctrl1_q[0]), .mask(word_mask),
        .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_wdata),
        .xfer_req(xfer_req), .xfer_out(xfer_out),
        .xfer_ack(xfer_ack), .xfer_in(xfer_in)
    );

    assign status  = {!tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
    assign raw_int = {(tx_cnt <= CNT_W'(HALF)), (rx_cnt >= CNT_W'(HALF)), 2'b00};
    assign irq     = |(raw_int & imask_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:5] == 7'h7F) begin
            bus_rdata = 32'(id_byte(bus_addr[4:2]));
        end else begin
            case (ofs)
                OFS_CTRL0:  bus_rdata = 32'(ctrl0_q);
                OFS_CTRL1:  bus_rdata = 32'(ctrl1_q);
                OFS_DATA:   bus_rdata = rx_empty ? '0 : 32'(rx_head);
                OFS_STAT:   bus_rdata = 32'(status);
                OFS_PRESC:  bus_rdata = 32'(presc_q);
                OFS_IMASK:  bus_rdata = 32'(imask_q);
                OFS_RAW:    bus_rdata = 32'(raw_int);
                OFS_MASKED: bus_rdata = 32'(raw_int & imask_q);
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [3:0]        ctrl1_q,
    input logic [3:0]        imask_q,
    input logic              tx_push_req,
    input logic              irq,
    input logic              xfer_req,
    input logic              xfer_ack,
    input logic [WORD_W-1:0] xfer_out
);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CNT_W'(DEPTH)) |=> (rx_cnt <= CNT_W'(DEPTH)));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_out)));

    // R6
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push_req && tx_cnt == CNT_W'(DEPTH)) |=> (tx_cnt <= $past(tx_cnt)));

    // R5
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl1_q[1] && !xfer_req) |=> !xfer_req);

    // R3
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl1_q[0] && !xfer_req) |=> !xfer_req);

    // R10
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0 && imask_q[3]) |-> irq);
endmodule

bind ssp_ctrl ssp_chk #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .ctrl1_q(ctrl1_q), .imask_q(imask_q),
    .tx_push_req(wr_en && (ofs == ssp_pkg::OFS_DATA)),
    .irq(irq), .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_out(xfer_out)
);

// File: tb/sim_ssp_ctrl.sv
module sim_ssp_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, xfer_req, xfer_ack = 1'b0;
    logic [15:0] xfer_out, xfer_in = '0;

    int checks = 0, errors = 0;
    int req_cycles = 0, ex_count = 0, unstable = 0, wait_cnt = 0;
    logic [15:0] first_out;
    logic [15:0] ex_log [8];

    ssp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .xfer_req(xfer_req), .xfer_out(xfer_out),
        .xfer_ack(xfer_ack), .xfer_in(xfer_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // exchange responder: acknowledges after three request cycles with the inverted word
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_req) req_cycles++;
            if (xfer_ack) begin
                xfer_ack = 1'b0;
            end else if (xfer_req) begin
                if (wait_cnt == 0) first_out = xfer_out;
                else if (xfer_out != first_out) unstable++;
                wait_cnt++;
                if (wait_cnt == 3) begin
                    xfer_ack = 1'b1;
                    xfer_in  = ~xfer_out;
                    if (ex_count < 8) ex_log[ex_count] = xfer_out;
                    ex_count++;
                    wait_cnt = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(12'h00C, d); chk("R1 R9 status", d, 32'h03);
        rd(12'h018, d); chk("R1 raw", d, 32'h08);
        rd(12'h014, d); chk("R1 mask", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rd(12'h008, d); chk("R8 empty read", d, 32'h0);
        rd(12'h00C, d); chk("R8 status unchanged", d, 32'h03);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(12'h000, 32'hFFFF_ABCF); rd(12'h000, d); chk("R12 ctrl0", d, 32'hABCF);
        wr(12'h010, 32'h1234);      rd(12'h010, d); chk("R12 prescale", d, 32'h34);
        wr(12'h020, 32'h5);         rd(12'h020, d); chk("R12 dma", d, 32'h0);
        wr(12'h040, 32'h77);        rd(12'h040, d); chk("R12 unmapped", d, 32'h0);
        wr(12'h004, 32'hF8);        rd(12'h004, d); chk("R12 ctrl1", d, 32'h8);
        wr(12'h004, 32'h0);
        rd(12'h00C, d); chk("R12 writes left queues alone", d, 32'h03);
    endtask

    task automatic t_id;
        logic [31:0] d;
        logic [7:0] exp_id [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4 * i), d);
            chk("R11 id byte", d, 32'(exp_id[i]));
        end
    endtask

    task automatic t_loop;
        logic [31:0] d;
        wr(12'h000, 32'h7);
        wr(12'h004, 32'h3);
        wr(12'h008, 32'h1A5); wr(12'h008, 32'h0C3); wr(12'h008, 32'h07F);
        idle(5);
        rd(12'h008, d); chk("R3 R2 loop word0", d, 32'hA5);
        rd(12'h008, d); chk("R3 loop word1", d, 32'hC3);
        rd(12'h008, d); chk("R3 loop word2", d, 32'h7F);
        chk("R3 no exchange request", 32'(req_cycles), 32'h0);
        // capture mask: word queued at full width, captured at 4 bits
        wr(12'h004, 32'h1);
        wr(12'h000, 32'hF);
        wr(12'h008, 32'hBEEF);
        wr(12'h000, 32'h3);
        wr(12'h004, 32'h3);
        idle(4);
        rd(12'h008, d); chk("R2 capture mask", d, 32'hF);
    endtask

    task automatic t_full;
        logic [31:0] d;
        wr(12'h004, 32'h1);
        wr(12'h000, 32'hF);
        for (int i = 0; i < 5; i++) wr(12'h008, 32'h300 + 32'(i));
        idle(3);
        rd(12'h00C, d); chk("R5 R9 disabled partial", d, 32'h12);
        rd(12'h018, d); chk("R10 raw tx above half", d, 32'h0);
        for (int i = 5; i < 8; i++) wr(12'h008, 32'h300 + 32'(i));
        rd(12'h00C, d); chk("R9 tx full status", d, 32'h10);
        wr(12'h008, 32'h3FF);
        wr(12'h004, 32'h3);
        idle(12);
        rd(12'h00C, d); chk("R9 rx full status", d, 32'h0F);
        rd(12'h018, d); chk("R10 raw both", d, 32'h0C);
        for (int i = 0; i < 8; i++) begin
            rd(12'h008, d); chk("R6 stored words", d, 32'h300 + 32'(i));
        end
        rd(12'h008, d); chk("R6 ninth dropped", d, 32'h0);
    endtask

    task automatic t_stall;
        logic [31:0] d;
        wr(12'h004, 32'h1);
        for (int i = 0; i < 8; i++) wr(12'h008, 32'h100 + 32'(i));
        wr(12'h004, 32'h3);
        idle(12);
        wr(12'h008, 32'h200); wr(12'h008, 32'h201);
        idle(4);
        rd(12'h00C, d); chk("R7 stalled", d, 32'h1E);
        rd(12'h008, d); chk("R7 first", d, 32'h100);
        idle(4);
        rd(12'h00C, d); chk("R7 one slot refilled", d, 32'h1E);
        for (int i = 1; i < 8; i++) begin
            rd(12'h008, d); chk("R7 order", d, 32'h100 + 32'(i));
        end
        rd(12'h008, d); chk("R7 resumed a", d, 32'h200);
        idle(3);
        rd(12'h008, d); chk("R7 resumed b", d, 32'h201);
        rd(12'h00C, d); chk("R7 drained", d, 32'h03);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(12'h014, 32'hC);
        rd(12'h01C, d); chk("R10 masked tx", d, 32'h08);
        chk("R10 irq tx", 32'(irq), 32'h1);
        wr(12'h014, 32'h4);
        chk("R10 irq masked off", 32'(irq), 32'h0);
        for (int i = 0; i < 4; i++) wr(12'h008, 32'h10 + 32'(i));
        idle(4);
        rd(12'h018, d); chk("R10 raw rx half", d, 32'h0C);
        rd(12'h01C, d); chk("R10 masked rx", d, 32'h04);
        chk("R10 irq rx", 32'(irq), 32'h1);
        rd(12'h008, d);
        rd(12'h018, d); chk("R10 raw below half", d, 32'h08);
        chk("R10 irq clear", 32'(irq), 32'h0);
        for (int i = 0; i < 3; i++) rd(12'h008, d);
        wr(12'h014, 32'h0);
    endtask

    task automatic t_ext;
        logic [31:0] d;
        wr(12'h000, 32'hB);
        wr(12'h004, 32'h2);
        wr(12'h008, 32'h1234);
        wr(12'h008, 32'h0ABC);
        idle(20);
        chk("R4 exchange count", 32'(ex_count), 32'h2);
        chk("R4 out word0", 32'(ex_log[0]), 32'h0234);
        chk("R4 out word1", 32'(ex_log[1]), 32'h0ABC);
        chk("R4 held stable", 32'(unstable), 32'h0);
        chk("R4 single in flight", 32'(req_cycles), 32'h6);
        rd(12'h008, d); chk("R4 R2 reply0", d, 32'hDCB);
        rd(12'h008, d); chk("R4 R2 reply1", d, 32'h543);
        wr(12'h004, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_regs;
        t_id;
        t_loop;
        t_full;
        t_stall;
        t_irq;
        t_ext;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule